// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the sequencing core of a boundary-scan test port. It is clocked by the test clock and moves through a fixed sixteen-state graph, steered only by the mode-select input sampled on each rising edge. The graph has a data branch and an instruction branch. Each branch has select, capture, shift, first exit, pause, second exit and update steps. From every state, five rising edges with mode-select high return the controller to its reset state.

From the current state the block decodes capture, shift and update strobes for an external data register. It holds a 4-bit instruction register behind a separate shift stage. It also holds a one-bit bypass register. The all-ones instruction selects the bypass register. Any other instruction raises a select flag, and the external register's serial output is then routed to the test data output. The serial output and its enable change on the falling edge of the clock, and the output is enabled only while a shift state is active.

Top module: `tap_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge of `tck`, the controller enters state code 0 (test-logic-reset), `ir_out` becomes all ones, and at the following falling edge `tdo_oe` and `tdo` become 0.
- R2: State codes on `state`: 0 test-logic-reset, 1 run-idle, 2 select-data, 3 capture-data, 4 shift-data, 5 exit1-data, 6 pause-data, 7 exit2-data, 8 update-data, 9 select-instr, 10 capture-instr, 11 shift-instr, 12 exit1-instr, 13 pause-instr, 14 exit2-instr, 15 update-instr. Code 0 holds on `tms`=1 and goes to 1 on 0. Code 1 holds on 0 and goes to 2 on 1.
- R3: Code 2 goes to 3 on `tms`=0 and to 9 on 1. In the data branch, capture goes to shift on 0 and to exit1 on 1. Shift holds on 0 and goes to exit1 on 1. Exit1 goes to pause on 0 and to update on 1. Pause holds on 0 and goes to exit2 on 1. Exit2 goes to shift on 0 and to update on 1. Update goes to 1 on 0 and to 2 on 1.
- R4: Code 9 goes to 10 on `tms`=0 and to 0 on 1. The instruction branch (codes 10 to 15) follows the same transition pattern as the data branch.
- R5: From any state, five consecutive rising edges with `tms`=1 put the controller in code 0. From shift-data, four such edges do not.
- R6: `capture_dr`, `shift_dr` and `update_dr` are high exactly in codes 3, 4 and 8 respectively, and are never high together.
- R7: A rising edge in capture-instr loads 4'b0001 into the instruction shift stage. Each rising edge in shift-instr shifts the stage toward bit 0, and `tdi` enters at bit 3, so bit 0 is presented first on `tdo`.
- R8: `ir_out` takes the shift-stage value only on the rising edge that leaves update-instr. It becomes all ones on a rising edge spent in code 0. At all other times it holds.
- R9: When `ir_out` is all ones (bypass), a rising edge in capture-data clears the bypass bit and each rising edge in shift-data loads `tdi` into it, so `tdo` gives `tdi` delayed by one clock, with a 0 first.
- R10: When `ir_out` is not all ones, `ext_sel` is 1 and, in shift-data, `tdo` follows `ext_dr_tdo`. In bypass, `ext_sel` is 0.
- R11: `tdo` and `tdo_oe` update only on falling edges of `tck`. `tdo_oe` is 1 exactly when the state at that falling edge is shift-data or shift-instr, and `tdo` is 0 whenever `tdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial test data in |
| ext_dr_tdo | input | 1 | Serial output of the external data register |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| tdo_oe | output | 1 | Output enable for tdo |
| state | output | 4 | Current controller state code (R2) |
| capture_dr | output | 1 | Capture strobe for the external data register |
| shift_dr | output | 1 | Shift strobe for the external data register |
| update_dr | output | 1 | Update strobe for the external data register |
| ext_sel | output | 1 | High when the instruction selects the external register |
| ir_out | output | 4 | Current instruction |

## Verification
On every cycle, the assertions check the reset-state hold, the five-high return to reset, the exclusivity of the decoded strobes, the capture pattern of the instruction stage, the holding of the instruction outside update and reset, the loading of the bypass bit, and the coupling of the output enable to the shift states. Only the bench scenarios show the full transition graph edge by edge, the bit order and values shifted through the instruction path, the one-clock delay of the bypass path, the switch to the external register's output after a new instruction, and the timing of the output update on the falling edge.

// File: rtl/tap_pkg.sv
// Shared types for the test access port controller.
// Assumes state codes are visible at the top ports, so the encoding is fixed.
package tap_pkg;
    typedef enum logic [3:0] {
        ST_RESET   = 4'd0,
        ST_IDLE    = 4'd1,
        ST_SEL_DR  = 4'd2,
        ST_CAP_DR  = 4'd3,
        ST_SH_DR   = 4'd4,
        ST_EX1_DR  = 4'd5,
        ST_PA_DR   = 4'd6,
        ST_EX2_DR  = 4'd7,
        ST_UPD_DR  = 4'd8,
        ST_SEL_IR  = 4'd9,
        ST_CAP_IR  = 4'd10,
        ST_SH_IR   = 4'd11,
        ST_EX1_IR  = 4'd12,
        ST_PA_IR   = 4'd13,
        ST_EX2_IR  = 4'd14,
        ST_UPD_IR  = 4'd15
    } tap_state_t;
endpackage

// File: rtl/tap_fsm.sv
// Sixteen-state controller sequencer.
// Assumes tms is stable around the rising edge of tck; reset is synchronous.
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state
);
    tap_state_t nxt;

    // Next state chosen purely from current state and tms
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
            ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
            ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_RESET;
        endcase
    end

    // State register with synchronous reset
    always_ff @(posedge tck) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= nxt;
    end

    // Checker: count consecutive high tms samples, saturating at 7
    logic [2:0] ones_cnt;
    always_ff @(posedge tck) begin
        if (!rst_n)         ones_cnt <= 3'd0;
        else if (!tms)      ones_cnt <= 3'd0;
        else if (ones_cnt != 3'd7) ones_cnt <= ones_cnt + 3'd1;
    end

    // R2
    reset_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_RESET && tms) |=> state == ST_RESET);

    // R5
    five_high_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (ones_cnt >= 3'd5) |-> state == ST_RESET);
endmodule

// File: rtl/tap_ir.sv
// Instruction shift stage and instruction output register.
// Assumes bit 0 leaves first; tdi enters at the top bit.
module tap_ir
    import tap_pkg::*;
#(
    parameter int          IR_W    = 4,
    parameter logic [IR_W-1:0] CAP_PAT = 4'b0001
) (
    input  logic            tck,
    input  logic            rst_n,
    input  tap_state_t      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_lsb
);
    localparam logic [IR_W-1:0] ALL_ONES = {IR_W{1'b1}};

    logic [IR_W-1:0] ir_sr;

    // Shift stage: capture fixed pattern, then shift toward bit 0
    always_ff @(posedge tck) begin
        if (!rst_n)                  ir_sr <= CAP_PAT;
        else if (state == ST_CAP_IR) ir_sr <= CAP_PAT;
        else if (state == ST_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Output register: load on update, force bypass in reset state
    always_ff @(posedge tck) begin
        if (!rst_n)                  ir_q <= ALL_ONES;
        else if (state == ST_RESET)  ir_q <= ALL_ONES;
        else if (state == ST_UPD_IR) ir_q <= ir_sr;
    end

    assign ir_lsb = ir_sr[0];

    // R7
    ir_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_IR) |=> ir_sr == CAP_PAT);

    // R8
    ir_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state != ST_UPD_IR && state != ST_RESET) |=> $stable(ir_q));
endmodule

// File: rtl/tap_bypass.sv
// One-bit bypass register between tdi and tdo.
// Assumes it is only meaningful while the bypass instruction is active.
module tap_bypass
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  tap_state_t state,
    input  logic       sel,
    input  logic       tdi,
    output logic       bp_q
);
    // Clear on capture, load tdi on shift, only while selected
    always_ff @(posedge tck) begin
        if (!rst_n)                          bp_q <= 1'b0;
        else if (sel && state == ST_CAP_DR)  bp_q <= 1'b0;
        else if (sel && state == ST_SH_DR)   bp_q <= tdi;
    end

    // R9
    bypass_shift_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (sel && state == ST_SH_DR) |=> bp_q == $past(tdi));
endmodule

// File: rtl/tap_ctrl.sv
// Top of the test access port controller: sequencer, strobe decode,
// instruction path, bypass path and falling-edge serial output.
// Assumes the external data register shifts on shift_dr at rising tck.
module tap_ctrl
    import tap_pkg::*;
#(
    parameter int IR_W = 4
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tms,
    input  logic            tdi,
    input  logic            ext_dr_tdo,
    output logic            tdo,
    output logic            tdo_oe,
    output logic [3:0]      state,
    output logic            capture_dr,
    output logic            shift_dr,
    output logic            update_dr,
    output logic            ext_sel,
    output logic [IR_W-1:0] ir_out
);
    localparam logic [IR_W-1:0] BYPASS_OP = {IR_W{1'b1}};

    tap_state_t st;
    logic       ir_lsb;
    logic       bp_q;
    logic       in_shift;
    logic       dr_bit;

    tap_fsm u_fsm (
        .tck   (tck),
        .rst_n (rst_n),
        .tms   (tms),
        .state (st)
    );

    tap_ir #(.IR_W(IR_W), .CAP_PAT({{(IR_W-1){1'b0}}, 1'b1})) u_ir (
        .tck    (tck),
        .rst_n  (rst_n),
        .state  (st),
        .tdi    (tdi),
        .ir_q   (ir_out),
        .ir_lsb (ir_lsb)
    );

    tap_bypass u_bp (
        .tck   (tck),
        .rst_n (rst_n),
        .state (st),
        .sel   (!ext_sel),
        .tdi   (tdi),
        .bp_q  (bp_q)
    );

    // Strobe decode for the external data register
    always_comb begin
        capture_dr = (st == ST_CAP_DR);
        shift_dr   = (st == ST_SH_DR);
        update_dr  = (st == ST_UPD_DR);
    end

    assign state    = st;
    assign ext_sel  = (ir_out != BYPASS_OP);
    assign in_shift = (st == ST_SH_DR) || (st == ST_SH_IR);
    assign dr_bit   = ext_sel ? ext_dr_tdo : bp_q;

    // Serial output retimed to the falling edge
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= in_shift;
            if (st == ST_SH_IR)      tdo <= ir_lsb;
            else if (st == ST_SH_DR) tdo <= dr_bit;
            else                     tdo <= 1'b0;
        end
    end

    // R6
    strobe_excl_chk: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0({capture_dr, shift_dr, update_dr}));

    // R11
    oe_shift_chk: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_oe |-> (st == ST_SH_DR || st == ST_SH_IR));

    // R11
    tdo_quiet_chk: assert property (@(posedge tck) disable iff (!rst_n)
        !tdo_oe |-> !tdo);
endmodule

// File: tb/sim_tap_ctrl.sv
module sim_tap_ctrl;
    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic       tms = 1'b1;
    logic       tdi = 1'b0;
    logic       ext_dr_tdo = 1'b0;
    logic       tdo, tdo_oe, capture_dr, shift_dr, update_dr, ext_sel;
    logic [3:0] state;
    logic [3:0] ir_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 tck = ~tck;

    tap_ctrl u0 (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .ext_dr_tdo(ext_dr_tdo),
        .tdo(tdo), .tdo_oe(tdo_oe), .state(state), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .ext_sel(ext_sel), .ir_out(ir_out)
    );

    // {tms, expected state after the rising edge}, walked from reset state
    localparam int NV = 40;
    localparam logic [4:0] VEC [NV] = '{
        {1'b1,4'd0},  {1'b0,4'd1},  {1'b0,4'd1},  {1'b1,4'd2},  {1'b0,4'd3},
        {1'b0,4'd4},  {1'b0,4'd4},  {1'b1,4'd5},  {1'b0,4'd6},  {1'b0,4'd6},
        {1'b1,4'd7},  {1'b0,4'd4},  {1'b1,4'd5},  {1'b1,4'd8},  {1'b1,4'd2},
        {1'b1,4'd9},  {1'b0,4'd10}, {1'b1,4'd12}, {1'b0,4'd13}, {1'b1,4'd14},
        {1'b0,4'd11}, {1'b1,4'd12}, {1'b1,4'd15}, {1'b1,4'd2},  {1'b0,4'd3},
        {1'b1,4'd5},  {1'b0,4'd6},  {1'b1,4'd7},  {1'b1,4'd8},  {1'b0,4'd1},
        {1'b1,4'd2},  {1'b1,4'd9},  {1'b0,4'd10}, {1'b0,4'd11}, {1'b1,4'd12},
        {1'b1,4'd15}, {1'b0,4'd1},  {1'b1,4'd2},  {1'b1,4'd9},  {1'b1,4'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive at falling edge, clock one rising edge, sample shortly after
    task automatic step(input logic m, input logic d);
        @(negedge tck);
        tms = m;
        tdi = d;
        @(posedge tck);
        #1;
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge tck);
        @(negedge tck); #1;
        check("R1 state", state, 4'd0);
        check("R1 ir_out", ir_out, 4'hF);
        check("R1 tdo_oe", tdo_oe, 1'b0);
        check("R1 tdo", tdo, 1'b0);
        rst_n = 1'b1;

        // R2 R3 R4 R6: table walk over the whole graph
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][4], 1'b0);
            check("R2/R3/R4 state", state, VEC[i][3:0]);
            check("R6 capture_dr", capture_dr, VEC[i][3:0] == 4'd3);
            check("R6 shift_dr", shift_dr, VEC[i][3:0] == 4'd4);
            check("R6 update_dr", update_dr, VEC[i][3:0] == 4'd8);
        end
        step(1'b1, 1'b0);
        check("R8 ir all ones in reset", ir_out, 4'hF);

        // R7 R11: load instruction 0101 through the instruction path
        step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0);
        step(1'b0, 1'b0); step(1'b0, 1'b0);
        check("R7 in shift-instr", state, 4'd11);
        check("R11 oe not yet set at rising edge", tdo_oe, 1'b0);
        step(1'b0, 1'b1);
        check("R11 oe in shift", tdo_oe, 1'b1);
        check("R7 bit0 of capture", tdo, 1'b1);
        step(1'b0, 1'b0);
        check("R7 bit1 of capture", tdo, 1'b0);
        step(1'b0, 1'b1);
        check("R7 bit2 of capture", tdo, 1'b0);
        step(1'b1, 1'b0);
        check("R7 bit3 of capture", tdo, 1'b0);
        check("R8 hold before update", ir_out, 4'hF);
        step(1'b1, 1'b0);
        check("R8 hold in update-instr", ir_out, 4'hF);
        check("R11 oe off outside shift", tdo_oe, 1'b0);
        step(1'b0, 1'b0);
        check("R8 load on update", ir_out, 4'h5);
        check("R10 ext_sel", ext_sel, 1'b1);

        // R10: external register routed in shift-data
        step(1'b1, 1'b0); step(1'b0, 1'b0);
        check("R6 capture_dr", capture_dr, 1'b1);
        step(1'b0, 1'b0);
        ext_dr_tdo = 1'b1;
        step(1'b0, 1'b0);
        check("R10 tdo follows ext 1", tdo, 1'b1);
        ext_dr_tdo = 1'b0;
        step(1'b0, 1'b1);
        check("R10 tdo follows ext 0", tdo, 1'b0);

        // R5: four highs from shift-data are not enough, five are
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0);
        check("R5 four highs", state, 4'd9);
        step(1'b1, 1'b0);
        check("R5 five highs", state, 4'd0);
        step(1'b1, 1'b0);
        check("R8 bypass restored", ir_out, 4'hF);
        check("R10 ext_sel off in bypass", ext_sel, 1'b0);

        // R9: bypass delays tdi by one clock, 0 first
        ext_dr_tdo = 1'b1;
        step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
        check("R9 in shift-data", state, 4'd4);
        step(1'b0, 1'b1);
        check("R9 captured zero", tdo, 1'b0);
        step(1'b0, 1'b0);
        check("R9 delayed 1", tdo, 1'b1);
        step(1'b0, 1'b1);
        check("R9 delayed 0", tdo, 1'b0);
        step(1'b1, 1'b1);
        check("R9 delayed 1 again", tdo, 1'b1);

        // R1: synchronous reset in the middle of a scan
        step(1'b0, 1'b0);
        check("R1 pause before reset", state, 4'd6);
        @(negedge tck); rst_n = 1'b0;
        @(posedge tck); #1;
        check("R1 mid-scan reset state", state, 4'd0);
        @(negedge tck); #1;
        check("R1 mid-scan tdo_oe", tdo_oe, 1'b0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule